// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block keeps the sticky floating-point exception flags and the dynamic rounding mode of a processor core. Software reaches the state through a CSR access port (address, write enable, write data, combinational read data). Three CSR addresses look at the same storage. One shows only the flags. One shows only the rounding mode. One combined control/status view shows both fields packed together.

Completed floating-point operations report their exception conditions on a retire-side accrual input. Those bits are ORed into the sticky flags, and they stay set until software clears them. Setting a flag never causes a trap.

The block also resolves the rounding-mode field of the instruction now in decode into an effective rounding mode. A field of 111 selects the stored dynamic mode. The block raises an illegal-encoding indication for reserved codes on either path. The decode is done for every instruction, including those whose result does not depend on rounding.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the flags are all zero and the stored rounding mode is 000, so all three views read zero.
- R2: Reading address 0x001 returns the flags in bits 4:0 with invalid at bit 4, divide-by-zero at bit 3, overflow at bit 2, underflow at bit 1 and inexact at bit 0. Reading 0x002 returns the rounding mode in bits 2:0. Reading 0x003 returns the flags in bits 4:0 and the rounding mode in bits 7:5. All other bits of every view read zero.
- R3: In a cycle with the accrual valid high, each set bit of the accrual flag vector sets the matching stored flag from the next cycle on. A flag never clears without a software write. The accrual vector has no effect while accrual valid is low.
- R4: A write to 0x001 replaces the flags with write-data bits 4:0 from the next cycle on. This can clear flags, and it leaves the rounding mode unchanged.
- R5: A write to 0x002 replaces the rounding mode with write-data bits 2:0. Any 3-bit value, including 111, is stored. Other write-data bits and the flags are unaffected. The mode changes only through writes to 0x002 or 0x003.
- R6: A write to 0x003 loads the flags from write-data bits 4:0 and the rounding mode from bits 7:5 in the same cycle.
- R7: When a flag-changing software write and an accrual fall in the same cycle, the stored flags become the written value ORed with the accrued flags.
- R8: Any address other than 0x001, 0x002 and 0x003 reads zero, and a write to it changes no state.
- R9: When the instruction rounding field is 000 to 110, the effective rounding mode equals that field. When it is 111, the effective mode equals the stored rounding mode.
- R10: Instruction field values 101 and 110 raise the illegal indication whatever the stored mode is. Field values 000 to 100 never raise it.
- R11: With instruction field 111, the illegal indication is raised exactly when the stored mode is 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for the addressed view (combinational) |
| acc_valid | input | 1 | A floating-point operation retires with its flags this cycle |
| acc_flags | input | 5 | Exception flags reported by the retiring operation |
| inst_rm | input | 3 | Rounding field of the instruction being decoded |
| eff_rm | output | 3 | Resolved effective rounding mode |
| rm_illegal | output | 1 | The rounding encoding in use is reserved |

## Verification
Accrual is tried with vectors that set disjoint bits, which separates OR-accumulation from plain loading. It is then driven with a valid-low vector, which exposes a missing gate on the valid. Writes carry all-ones in the unused data bits, which reveals field-slice and alias mistakes between the three views. A write that lands in the same cycle as an accrual tells apart a design that lets the write win from one that merges both. Resolution is tried with every static reserved code and with the stored mode set to a legal value, to 111 and to 101. This separates the static reserved check from the dynamic one.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

   localparam int FLAG_W = 5;
   localparam int RM_W   = 3;

   // flag bit positions inside every flags view
   localparam int FLG_NX = 0;
   localparam int FLG_UF = 1;
   localparam int FLG_OF = 2;
   localparam int FLG_DZ = 3;
   localparam int FLG_NV = 4;

   typedef logic [FLAG_W-1:0] fp_flags_t;

   typedef enum logic [RM_W-1:0] {
      RMODE_NEAR_EVEN = 3'b000,
      RMODE_TO_ZERO   = 3'b001,
      RMODE_DOWN      = 3'b010,
      RMODE_UP        = 3'b011,
      RMODE_NEAR_MAX  = 3'b100,
      RMODE_RSV5      = 3'b101,
      RMODE_RSV6      = 3'b110,
      RMODE_FROM_REG  = 3'b111
   } rmode_e;

   typedef enum logic [1:0] {
      VIEW_NONE  = 2'd0,
      VIEW_FLAGS = 2'd1,
      VIEW_RMODE = 2'd2,
      VIEW_BOTH  = 2'd3
   } csr_view_e;

   function automatic logic rm_bad_static(input logic [RM_W-1:0] code);
      return (code == RMODE_RSV5) || (code == RMODE_RSV6);
   endfunction

   function automatic logic rm_bad_dynamic(input logic [RM_W-1:0] code);
      return (code == RMODE_RSV5) || (code == RMODE_RSV6) || (code == RMODE_FROM_REG);
   endfunction

endpackage

// File: rtl/fpcsr_view.sv
module fpcsr_view
   import fpcsr_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] ADDR_FLAGS = 12'h001,
   parameter logic [11:0] ADDR_RMODE = 12'h002,
   parameter logic [11:0] ADDR_BOTH  = 12'h003
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [XLEN-1:0]   wdata,
   input  fp_flags_t         flags_q,
   input  logic [RM_W-1:0]   rm_q,
   output logic              wr_flags,
   output logic              wr_rm,
   output fp_flags_t         wflags,
   output logic [RM_W-1:0]   wrm,
   output logic [XLEN-1:0]   rdata
);
   localparam int PACK_W = FLAG_W + RM_W;
   localparam int HI_W   = XLEN - PACK_W;

   csr_view_e sel;
   logic [HI_W-1:0] wdata_unused;

   assign wdata_unused = wdata[XLEN-1:PACK_W];

   always_comb begin
      if (addr == ADDR_W'(ADDR_FLAGS))      sel = VIEW_FLAGS;
      else if (addr == ADDR_W'(ADDR_RMODE)) sel = VIEW_RMODE;
      else if (addr == ADDR_W'(ADDR_BOTH))  sel = VIEW_BOTH;
      else                                  sel = VIEW_NONE;
   end

   // write steering: both fields live in one shared store
   always_comb begin
      wr_flags = we && (sel == VIEW_FLAGS || sel == VIEW_BOTH);
      wr_rm    = we && (sel == VIEW_RMODE || sel == VIEW_BOTH);
      wflags   = wdata[FLAG_W-1:0];
      wrm      = (sel == VIEW_BOTH) ? wdata[PACK_W-1:FLAG_W] : wdata[RM_W-1:0];
   end

   // read slices, zero-extended to the register width
   always_comb begin
      unique case (sel)
         VIEW_FLAGS: rdata = XLEN'(flags_q);
         VIEW_RMODE: rdata = XLEN'(rm_q);
         VIEW_BOTH:  rdata = XLEN'({rm_q, flags_q});
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/fpcsr_store.sv
module fpcsr_store
   import fpcsr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_flags,
   input  logic            wr_rm,
   input  fp_flags_t       wflags,
   input  logic [RM_W-1:0] wrm,
   input  logic            acc_valid,
   input  fp_flags_t       acc_flags,
   output fp_flags_t       flags_q,
   output logic [RM_W-1:0] rm_q
);
   fp_flags_t acc_hit;

   assign acc_hit = acc_valid ? acc_flags : '0;

   // one sticky cell per flag: software write merges with same-cycle accrual
   for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
      logic base;
      assign base = wr_flags ? wflags[b] : flags_q[b];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[b] <= 1'b0;
         else        flags_q[b] <= base | acc_hit[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rm_q <= RMODE_NEAR_EVEN;
      else if (wr_rm) rm_q <= wrm;
   end

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)))
      else $error("flag cleared without write"); // R3

   AST_ACCRUE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> ((flags_q & $past(acc_flags)) == $past(acc_flags)))
      else $error("accrued flag lost"); // R7

   AST_RM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rm |=> $stable(rm_q))
      else $error("rounding mode changed without write"); // R5

endmodule

// File: rtl/fpcsr_resolve.sv
module fpcsr_resolve
   import fpcsr_pkg::*;
(
   input  logic [RM_W-1:0] inst_rm,
   input  logic [RM_W-1:0] rm_q,
   output logic [RM_W-1:0] eff_rm,
   output logic            illegal
);
   logic use_dyn;

   assign use_dyn = (inst_rm == RMODE_FROM_REG);

   always_comb begin
      eff_rm  = use_dyn ? rm_q : inst_rm;
      illegal = use_dyn ? rm_bad_dynamic(rm_q) : rm_bad_static(inst_rm);
   end

   always_comb begin
      if (!use_dyn) assert (eff_rm == inst_rm) else $error("static rm not passed"); // R9
   end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
   import fpcsr_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] ADDR_FLAGS = 12'h001,
   parameter logic [11:0] ADDR_RMODE = 12'h002,
   parameter logic [11:0] ADDR_BOTH  = 12'h003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_we,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              acc_valid,
   input  logic [4:0]        acc_flags,
   input  logic [2:0]        inst_rm,
   output logic [2:0]        eff_rm,
   output logic              rm_illegal
);
   localparam int PACK_W = FLAG_W + RM_W;

   if (XLEN <= PACK_W) begin : g_bad_xlen
      $error("XLEN must exceed the packed field width");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   logic            wr_flags, wr_rm;
   fp_flags_t       wflags, flags_q;
   logic [RM_W-1:0] wrm, rm_q;

   fpcsr_view #(
      .XLEN(XLEN), .ADDR_W(ADDR_W),
      .ADDR_FLAGS(ADDR_FLAGS), .ADDR_RMODE(ADDR_RMODE), .ADDR_BOTH(ADDR_BOTH)
   ) u_view (
      .addr(csr_addr), .we(csr_we), .wdata(csr_wdata),
      .flags_q(flags_q), .rm_q(rm_q),
      .wr_flags(wr_flags), .wr_rm(wr_rm), .wflags(wflags), .wrm(wrm),
      .rdata(csr_rdata)
   );

   fpcsr_store u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_flags(wr_flags), .wr_rm(wr_rm), .wflags(wflags), .wrm(wrm),
      .acc_valid(acc_valid), .acc_flags(acc_flags),
      .flags_q(flags_q), .rm_q(rm_q)
   );

   fpcsr_resolve u_resolve (
      .inst_rm(inst_rm), .rm_q(rm_q),
      .eff_rm(eff_rm), .illegal(rm_illegal)
   );

   AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[XLEN-1:PACK_W] == '0)
      else $error("unused read bits set"); // R2

   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr != ADDR_W'(ADDR_FLAGS) && csr_addr != ADDR_W'(ADDR_RMODE) &&
       csr_addr != ADDR_W'(ADDR_BOTH)) |-> csr_rdata == '0)
      else $error("unmapped address read nonzero"); // R8

   AST_STATIC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_rm != 3'b111 && !rm_illegal) |-> eff_rm <= 3'b100)
      else $error("reserved static mode accepted"); // R10

   AST_DYN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_rm == 3'b111 && !rm_illegal) |-> eff_rm <= 3'b100)
      else $error("reserved dynamic mode accepted"); // R11

endmodule

// File: tb/fpcsr_unit_tb_top.sv
module fpcsr_unit_tb_top;

   typedef struct {
      bit          is_rm;
      logic [31:0] exp;
      logic        exp_ill;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        acc_valid = 1'b0;
   logic [4:0]  acc_flags = '0;
   logic [2:0]  inst_rm = '0;
   logic [2:0]  eff_rm;
   logic        rm_illegal;

   logic        probe_v = 1'b0;
   item_t       sb_q[$];
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   // bench reference state, kept from the requirements
   logic [4:0]  m_flags = '0;
   logic [2:0]  m_rm = '0;

   always #10 clk = ~clk;

   fpcsr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .acc_valid(acc_valid),
      .acc_flags(acc_flags), .inst_rm(inst_rm), .eff_rm(eff_rm),
      .rm_illegal(rm_illegal)
   );

   // monitor: compares outputs before the edge updates any state
   always @(posedge clk) begin
      if (probe_v && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         total++;
         if (!it.is_rm) begin
            if (csr_rdata !== it.exp) begin
               bad++;
               $display("FAIL %s rdata=%h expected=%h", it.tag, csr_rdata, it.exp);
            end
         end else begin
            if (eff_rm !== it.exp[2:0] || rm_illegal !== it.exp_ill) begin
               bad++;
               $display("FAIL %s eff=%0d ill=%0b expected eff=%0d ill=%0b",
                        it.tag, eff_rm, rm_illegal, it.exp[2:0], it.exp_ill);
            end
         end
      end
   end

   task automatic drive(input logic [11:0] a, input logic w, input logic [31:0] d,
                        input logic av, input logic [4:0] af);
      @(negedge clk);
      probe_v   = 1'b0;
      csr_addr  = a;
      csr_we    = w;
      csr_wdata = d;
      acc_valid = av;
      acc_flags = af;
      // reference update
      if (w && (a == 12'h001 || a == 12'h003)) m_flags = d[4:0];
      if (w && a == 12'h002) m_rm = d[2:0];
      if (w && a == 12'h003) m_rm = d[7:5];
      if (av) m_flags = m_flags | af;
   endtask

   task automatic exp_read(input logic [11:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      csr_addr  = a;
      csr_we    = 1'b0;
      acc_valid = 1'b0;
      it.is_rm = 1'b0; it.exp = e; it.exp_ill = 1'b0; it.tag = tag;
      sb_q.push_back(it);
      probe_v = 1'b1;
   endtask

   task automatic exp_rm(input logic [2:0] f, input logic [2:0] e, input logic ill,
                         input string tag);
      item_t it;
      @(negedge clk);
      csr_we    = 1'b0;
      acc_valid = 1'b0;
      inst_rm   = f;
      it.is_rm = 1'b1; it.exp = {29'd0, e}; it.exp_ill = ill; it.tag = tag;
      sb_q.push_back(it);
      probe_v = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      exp_read(12'h001, 32'h0, "R1 flags after reset");
      exp_read(12'h002, 32'h0, "R1 rm after reset");
      exp_read(12'h003, 32'h0, "R1 combined after reset");

      drive(12'h000, 1'b0, 32'h0, 1'b1, 5'b00101);
      exp_read(12'h001, 32'h05, "R3 first accrual");
      drive(12'h000, 1'b0, 32'h0, 1'b1, 5'b10000);
      exp_read(12'h001, 32'h15, "R3 accrual ORs in");
      drive(12'h000, 1'b0, 32'h0, 1'b0, 5'b01010);
      exp_read(12'h001, 32'h15, "R3 accrual ignored when not valid");

      drive(12'h001, 1'b1, 32'h0, 1'b0, 5'b0);
      exp_read(12'h001, 32'h0, "R4 software clear");
      drive(12'h001, 1'b1, 32'hFFFF_FFFF, 1'b0, 5'b0);
      exp_read(12'h001, 32'h1F, "R2 flags view upper bits zero");
      exp_read(12'h002, 32'h0, "R4 flags write leaves rm");

      drive(12'h002, 1'b1, 32'hFFFF_FFFB, 1'b0, 5'b0);
      exp_read(12'h002, 32'h3, "R5 rm view write");
      exp_read(12'h001, 32'h1F, "R5 rm write leaves flags");
      exp_read(12'h003, 32'h7F, "R2 combined packing");

      drive(12'h003, 1'b1, 32'hFFFF_FF89, 1'b0, 5'b0);
      exp_read(12'h003, 32'h89, "R6 combined write");
      exp_read(12'h001, 32'h09, "R6 flags alias");
      exp_read(12'h002, 32'h4, "R6 rm alias");

      drive(12'h001, 1'b1, 32'h2, 1'b1, 5'b10000);
      exp_read(12'h001, 32'h12, "R7 write merged with accrual");
      drive(12'h003, 1'b1, 32'h80, 1'b1, 5'b00001);
      exp_read(12'h003, 32'h81, "R7 combined write merged with accrual");

      drive(12'h004, 1'b1, 32'hFFFF_FFFF, 1'b0, 5'b0);
      exp_read(12'h004, 32'h0, "R8 unmapped reads zero");
      exp_read(12'h003, 32'h81, "R8 unmapped write ignored");
      exp_read(12'h7FF, 32'h0, "R8 high unmapped reads zero");

      exp_rm(3'b001, 3'b001, 1'b0, "R9 static pass");
      exp_rm(3'b100, 3'b100, 1'b0, "R9 static max-magnitude");
      exp_rm(3'b111, 3'b100, 1'b0, "R9 dynamic selects stored");
      exp_rm(3'b101, 3'b101, 1'b1, "R10 static 101 reserved");
      exp_rm(3'b110, 3'b110, 1'b1, "R10 static 110 reserved");

      drive(12'h002, 1'b1, 32'h7, 1'b0, 5'b0);
      exp_read(12'h002, 32'h7, "R5 stores 111");
      exp_rm(3'b111, 3'b111, 1'b1, "R11 dynamic 111 reserved");
      exp_rm(3'b010, 3'b010, 1'b0, "R10 static legal despite bad stored mode");
      drive(12'h002, 1'b1, 32'h5, 1'b0, 5'b0);
      exp_rm(3'b111, 3'b101, 1'b1, "R11 dynamic 101 reserved");
      drive(12'h002, 1'b1, 32'h6, 1'b0, 5'b0);
      exp_rm(3'b111, 3'b110, 1'b1, "R11 dynamic 110 reserved");
      drive(12'h002, 1'b1, 32'h1, 1'b0, 5'b0);
      exp_rm(3'b111, 3'b001, 1'b0, "R11 dynamic legal");

      // bench model agrees with final state
      exp_read(12'h003, {24'd0, m_rm, m_flags}, "R2 final combined view");

      @(negedge clk);
      probe_v = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule